// File: doc/BRIEF.md
# Entropy Health Monitor Status Unit

This unit sits next to a random-number generator and checks the raw entropy bits it produces. The source presents one bit per cycle in which `smp_vld` is high. Samples count only while the generator is enabled. The unit tracks two patterns. The first is a long run of identical bits. The second is a long stretch in which every sample differs from the one before it. Either pattern raises a live seed-error flag, which drops again as soon as a sample breaks the pattern.

A second live flag follows an external clock-error indication, unless clock checking is switched off. Each live flag has a sticky twin. The sticky flag is set when its live flag rises and stays set until software writes a 0 to it.

The unit also keeps a data-ready flag for a one-word output buffer. The flag is set when a word is loaded and cleared when software reads the buffer. Software sees all five flags in one status word. An interrupt line combines the sticky flags and data-ready under an enable input.

Top module: `ehm_status_unit`

## Requirements
- R1: After a counted sample, the live seed-error flag (status bit 2) reads 1 when more than 64 consecutive counted samples have had the same value, 0 or 1. After exactly 64 identical samples it reads 0.
- R2: The live seed-error flag reads 1 when more than 32 consecutive alternations occur between counted samples. 33 alternating samples (32 alternations) leave it at 0, and the 34th sets it.
- R3: The sticky seed-error flag (status bit 6) becomes 1 in the same cycle that the live seed-error flag becomes 1.
- R4: The live clock-error flag (status bit 1) shows the clock-error input one cycle later. The sticky clock-error flag (status bit 5) becomes 1 in the same cycle that the live clock-error flag becomes 1.
- R5: A status write with a 0 in bit 5 or bit 6 clears that sticky flag. Writing 1 has no effect. If a set event and a clearing write fall in the same cycle, the flag ends up set.
- R6: `irq` is 1 exactly when `irq_en` is 1 and at least one of data-ready, sticky clock error or sticky seed error is 1.
- R7: Data-ready (status bit 0) goes to 1 the cycle after `word_load`. It goes to 0 the cycle after `dr_rd` and stays 0 until the next load. If a load and a read arrive in the same cycle, the load wins.
- R8: Data-ready rises on `word_load` even while `gen_en` is 0.
- R9: While `clk_chk_off` is 1, the clock-error input never sets the live or the sticky clock-error flag.
- R10: The live seed-error flag returns to 0 on the first counted sample that breaks the offending pattern. The run and alternation counters saturate, so the flag stays 1 through arbitrarily long stuck runs.
- R11: Samples presented while `gen_en` is 0 do not affect the pattern tests.
- R12: Status bits 3, 4 and 7 to 31 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Raw entropy sample strobe |
| smp_bit | input | 1 | Raw entropy sample value |
| gen_en | input | 1 | Generator enable; gates sample counting |
| clk_err_in | input | 1 | Clock-error indication from the frequency checker |
| clk_chk_off | input | 1 | Disables clock-error flagging |
| irq_en | input | 1 | Interrupt enable |
| word_load | input | 1 | A new random word entered the output buffer |
| dr_rd | input | 1 | The output data word is being read |
| st_wr | input | 1 | Status register write strobe |
| st_wdata | input | 32 | Status register write data |
| st_rdata | output | 32 | Status register read value |
| irq | output | 1 | Interrupt request |

## Verification
A run counter that wraps or miscounts would show up on status bit 2 at the exact sample where the flag should change. Off-by-one errors appear at the 64th/65th identical sample or at the 33rd/34th alternating sample. A wrap appears partway through a very long stuck stream. A sticky flag that is lost or set late shows on bits 5 and 6, and on `irq`, in the cycle after the live flag rises. A data-ready register with the wrong priority is exposed on bit 0 by the load-and-read collision one cycle after the strobes.

// File: rtl/ehm_pkg.sv
package ehm_pkg;
  localparam int STW       = 32;
  localparam int NUM_ERR   = 2;
  localparam int IDX_CLK   = 0;
  localparam int IDX_SEED  = 1;
  localparam int RDY_POS   = 0;
  localparam int LIVE_BASE = 1;  // live flags at 1 (clock), 2 (seed)
  localparam int STK_BASE  = 5;  // sticky flags at 5 (clock), 6 (seed)

  function automatic int live_pos(input int idx);
    return LIVE_BASE + idx;
  endfunction

  function automatic int stk_pos(input int idx);
    return STK_BASE + idx;
  endfunction
endpackage

// File: rtl/ehm_pattern_mon.sv
module ehm_pattern_mon #(
  parameter int RUN_LIM = 64,
  parameter int ALT_LIM = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_en,
  input  logic smp_bit,
  output logic seed_nxt
);
  localparam int RW = $clog2(RUN_LIM + 2);
  localparam int AW = $clog2(ALT_LIM + 2);
  localparam logic [RW-1:0] RUN_TOP = RW'(RUN_LIM + 1);
  localparam logic [AW-1:0] ALT_TOP = AW'(ALT_LIM + 1);

  logic          have_q, have_n;
  logic          prev_q, prev_n;
  logic [RW-1:0] run_q, run_n;
  logic [AW-1:0] alt_q, alt_n;

  always_comb begin
    have_n = have_q;
    prev_n = prev_q;
    run_n  = run_q;
    alt_n  = alt_q;
    if (smp_en) begin
      have_n = 1'b1;
      prev_n = smp_bit;
      if (!have_q) begin
        run_n = RW'(1);
        alt_n = '0;
      end else if (smp_bit == prev_q) begin
        run_n = (run_q == RUN_TOP) ? run_q : run_q + RW'(1);
        alt_n = '0;
      end else begin
        run_n = RW'(1);
        alt_n = (alt_q == ALT_TOP) ? alt_q : alt_q + AW'(1);
      end
    end
  end

  assign seed_nxt = (run_n > RW'(RUN_LIM)) || (alt_n > AW'(ALT_LIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      prev_q <= 1'b0;
      run_q  <= '0;
      alt_q  <= '0;
    end else if (smp_en) begin
      have_q <= have_n;
      prev_q <= prev_n;
      run_q  <= run_n;
      alt_q  <= alt_n;
    end
  end

  // R10
  run_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_TOP);
  // R10
  alt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alt_q <= ALT_TOP);
  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> $stable(run_q) && $stable(alt_q));
endmodule

// File: rtl/ehm_err_pair.sv
module ehm_err_pair (
  input  logic clk,
  input  logic rst_n,
  input  logic cond,
  input  logic clr,
  output logic live,
  output logic sticky
);
  logic live_n, sticky_n, set_ev;

  assign set_ev = cond & ~live;

  always_comb begin
    live_n   = cond;
    sticky_n = sticky;
    if (clr)    sticky_n = 1'b0;
    if (set_ev) sticky_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live   <= 1'b0;
      sticky <= 1'b0;
    end else begin
      live   <= live_n;
      sticky <= sticky_n;
    end
  end

  // R3 R4
  sticky_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live) |-> sticky);
  // R5
  sticky_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sticky) |-> $past(clr));
endmodule

// File: rtl/ehm_ready_ctl.sv
module ehm_ready_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic word_load,
  input  logic dr_rd,
  output logic rdy
);
  logic rdy_n;

  always_comb begin
    rdy_n = rdy;
    if (dr_rd)     rdy_n = 1'b0;
    if (word_load) rdy_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy <= 1'b0;
    else        rdy <= rdy_n;
  end

  // R7 R8
  rdy_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_load |=> rdy);
  // R7
  rdy_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dr_rd && !word_load |=> !rdy);
endmodule

// File: rtl/ehm_status_unit.sv
module ehm_status_unit
  import ehm_pkg::*;
#(
  parameter int RUN_LIM = 64,
  parameter int ALT_LIM = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           smp_vld,
  input  logic           smp_bit,
  input  logic           gen_en,
  input  logic           clk_err_in,
  input  logic           clk_chk_off,
  input  logic           irq_en,
  input  logic           word_load,
  input  logic           dr_rd,
  input  logic           st_wr,
  input  logic [STW-1:0] st_wdata,
  output logic [STW-1:0] st_rdata,
  output logic           irq
);
  logic [NUM_ERR-1:0] cond, clr, live, sticky;
  logic               seed_nxt, rdy;
  logic               wdata_unused;

  assign wdata_unused = ^st_wdata;

  ehm_pattern_mon #(.RUN_LIM(RUN_LIM), .ALT_LIM(ALT_LIM)) u_mon (
    .clk     (clk),
    .rst_n   (rst_n),
    .smp_en  (smp_vld & gen_en),
    .smp_bit (smp_bit),
    .seed_nxt(seed_nxt)
  );

  assign cond[IDX_CLK]  = clk_err_in & ~clk_chk_off;
  assign cond[IDX_SEED] = seed_nxt;

  for (genvar i = 0; i < NUM_ERR; i++) begin : g_err
    assign clr[i] = st_wr & ~st_wdata[stk_pos(i)];
    ehm_err_pair u_pair (
      .clk   (clk),
      .rst_n (rst_n),
      .cond  (cond[i]),
      .clr   (clr[i]),
      .live  (live[i]),
      .sticky(sticky[i])
    );
  end

  ehm_ready_ctl u_rdy (
    .clk      (clk),
    .rst_n    (rst_n),
    .word_load(word_load),
    .dr_rd    (dr_rd),
    .rdy      (rdy)
  );

  always_comb begin
    st_rdata          = '0;
    st_rdata[RDY_POS] = rdy;
    for (int k = 0; k < NUM_ERR; k++) begin
      st_rdata[live_pos(k)] = live[k];
      st_rdata[stk_pos(k)]  = sticky[k];
    end
  end

  assign irq = irq_en & (rdy | (|sticky));

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> irq_en);
  // R9
  clk_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clk_chk_off |=> !live[IDX_CLK]);
endmodule

// File: tb/sim_ehm_status_unit.sv
`timescale 1ns/1ps
module sim_ehm_status_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        smp_vld, smp_bit, gen_en, clk_err_in, clk_chk_off, irq_en;
  logic        word_load, dr_rd, st_wr;
  logic [31:0] st_wdata, st_rdata;
  logic        irq;
  int          n_chk = 0;
  int          n_bad = 0;

  always #2.5 clk = ~clk;

  ehm_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_bit(smp_bit),
    .gen_en(gen_en), .clk_err_in(clk_err_in), .clk_chk_off(clk_chk_off),
    .irq_en(irq_en), .word_load(word_load), .dr_rd(dr_rd), .st_wr(st_wr),
    .st_wdata(st_wdata), .st_rdata(st_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; smp_vld = 0; smp_bit = 0; gen_en = 1; clk_err_in = 0;
    clk_chk_off = 0; irq_en = 0; word_load = 0; dr_rd = 0; st_wr = 0;
    st_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    smp_vld = 1; smp_bit = b;
    @(negedge clk);
    smp_vld = 0;
  endtask

  task automatic wr_status(input logic [31:0] d);
    st_wr = 1; st_wdata = d;
    @(negedge clk);
    st_wr = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R12 reset status", st_rdata, 32'h0);
    check("R6 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_run(input logic v);
    do_reset();
    for (int i = 0; i < 64; i++) send_bit(v);
    check("R1 64 identical", {31'b0, st_rdata[2]}, 32'h0);
    send_bit(v);
    check("R1 65 identical", {31'b0, st_rdata[2]}, 32'h1);
    check("R3 sticky with live", {31'b0, st_rdata[6]}, 32'h1);
    send_bit(~v);
    check("R10 break clears live", {31'b0, st_rdata[2]}, 32'h0);
    check("R3 sticky persists", {31'b0, st_rdata[6]}, 32'h1);
    check("R12 zero bits", st_rdata & 32'hFFFF_FF98, 32'h0);
  endtask

  task automatic t_alt();
    do_reset();
    for (int i = 0; i < 33; i++) send_bit(i[0]);
    check("R2 32 alternations", {31'b0, st_rdata[2]}, 32'h0);
    send_bit(1'b1);
    check("R2 33 alternations", {31'b0, st_rdata[2]}, 32'h1);
    send_bit(1'b1);
    check("R10 alt break clears", {31'b0, st_rdata[2]}, 32'h0);
    wr_status(32'hFFFF_FFFF);
    check("R5 write 1 ignored", {31'b0, st_rdata[6]}, 32'h1);
    wr_status(32'h0);
    check("R5 write 0 clears", {31'b0, st_rdata[6]}, 32'h0);
  endtask

  task automatic t_sat();
    do_reset();
    for (int i = 0; i < 300; i++) send_bit(1'b0);
    check("R10 long run saturates", {31'b0, st_rdata[2]}, 32'h1);
  endtask

  task automatic t_set_wins();
    do_reset();
    for (int i = 0; i < 64; i++) send_bit(1'b1);
    smp_vld = 1; smp_bit = 1; st_wr = 1; st_wdata = 32'h0;
    @(negedge clk);
    smp_vld = 0; st_wr = 0;
    check("R5 set beats clear", {31'b0, st_rdata[6]}, 32'h1);
  endtask

  task automatic t_clk();
    do_reset();
    clk_err_in = 1;
    @(negedge clk);
    check("R4 live clock error", {31'b0, st_rdata[1]}, 32'h1);
    check("R4 sticky clock error", {31'b0, st_rdata[5]}, 32'h1);
    clk_err_in = 0;
    @(negedge clk);
    check("R4 live follows input", {31'b0, st_rdata[1]}, 32'h0);
    wr_status(32'hFFFF_FFDF);
    check("R5 clear clock sticky", {31'b0, st_rdata[5]}, 32'h0);
    clk_chk_off = 1; clk_err_in = 1;
    repeat (3) @(negedge clk);
    check("R9 disabled clock check", st_rdata & 32'h22, 32'h0);
    clk_err_in = 0; clk_chk_off = 0;
  endtask

  task automatic t_ready();
    do_reset();
    gen_en = 0; word_load = 1;
    @(negedge clk);
    word_load = 0;
    check("R8 ready while disabled", {31'b0, st_rdata[0]}, 32'h1);
    check("R6 irq masked", {31'b0, irq}, 32'h0);
    irq_en = 1;
    #1;
    check("R6 irq on ready", {31'b0, irq}, 32'h1);
    dr_rd = 1;
    @(negedge clk);
    dr_rd = 0;
    check("R7 read clears ready", {31'b0, st_rdata[0]}, 32'h0);
    repeat (2) @(negedge clk);
    check("R7 stays empty", {31'b0, st_rdata[0]}, 32'h0);
    check("R6 irq drops", {31'b0, irq}, 32'h0);
    word_load = 1; dr_rd = 1;
    @(negedge clk);
    word_load = 0; dr_rd = 0;
    check("R7 load wins", {31'b0, st_rdata[0]}, 32'h1);
  endtask

  task automatic t_gate();
    do_reset();
    gen_en = 0;
    for (int i = 0; i < 100; i++) send_bit(1'b1);
    gen_en = 1;
    for (int i = 0; i < 64; i++) send_bit(1'b1);
    check("R11 gated samples ignored", {31'b0, st_rdata[2]}, 32'h0);
    irq_en = 1;
    send_bit(1'b1);
    check("R6 irq on seed sticky", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_run(1'b1);
        t_run(1'b0);
        t_alt();
        t_sat();
        t_set_wins();
        t_clk();
        t_ready();
        t_gate();
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      end
    join_any
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule